// File: doc/BRIEF.md
# Write Permission and Page Lock Controller

This block decides whether a write into a small paged non-volatile memory may proceed. It keeps two volatile permission latches and a set of persistent control fields: an upper-array lock size, a watchdog interval select and a trip-adjust enable. A bus front end passes it decoded control-register writes with their data byte, a stop event, and memory write requests tagged with a page index. One cycle after each request the block answers with either a grant or a deny pulse.

Software must first arm the write latch. Then it may arm the register latch. Only after both are armed can it stage new persistent field values. A staged value is committed on the following stop event, and the commit is shown by a one-cycle strobe. An external write-protect pin freezes the lock-size field. Locked pages are counted down from the highest page of the array.

Top module: `wpl_write_guard`

## Requirements
- R1: After reset the register reads 00h, and grant, deny and commit strobe are all low.
- R2: Register layout: bit0 trip-adjust enable, bit1 write latch, bit2 register latch, bits[5:3] lock code, bits[7:6] watchdog select. Writing 02h sets the write latch. Writing 00h while the register latch is clear clears the write latch.
- R3: Writing 06h sets the register latch only while the write latch is set; otherwise the register keeps its value.
- R4: A memory write requested while the write latch is clear gives a deny pulse one cycle later and leaves the register value unchanged.
- R5: Lock codes 000 none, 001 top 1 page, 010 top 2, 011 top 4, 100 top 8, 101 all pages, 110 and 111 none. With the write latch set, a request to a locked page is denied and any other page is granted. Grant and deny are never high together.
- R6: A register write with bit2 = 0 while the register latch is set stages bits 7:3, 1 and 0 without changing the readback. On the next stop those fields take the staged values, the register latch clears, and the commit strobe is high for the one cycle after the stop.
- R7: The sequence 02h, 06h, 02h followed by a stop returns all persistent fields to 0, and the register reads 02h.
- R8: A denied write to a locked page while the write latch is set clears the register latch and discards any staged update, so a later stop commits nothing.
- R9: When the write-protect pin is high at commit, the lock code keeps its old value while the other staged fields still update, and the locked pages stay denied.
- R10: With the register latch clear, register values other than 00h, 02h and 06h are ignored.
- R11: A stop with nothing staged changes no state and gives no commit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| reg_wr_i | input | 1 | Control-register write event |
| reg_data_i | input | 8 | Data byte of the register write |
| stop_i | input | 1 | Bus stop event |
| mem_req_i | input | 1 | Memory write request |
| mem_page_i | input | PAGE_W | Page index of the request |
| wp_i | input | 1 | Write-protect pin, active high |
| mem_grant_o | output | 1 | Write permitted, one cycle after request |
| mem_deny_o | output | 1 | Write refused, one cycle after request |
| reg_rdata_o | output | 8 | Current register value |
| nv_commit_o | output | 1 | Persistent fields committed |

## Verification
The main function is the lock decode. It is tried with each lock code paired with the lowest locked page and the highest free page, so that an off-by-one in the boundary or a swapped code shows up. Codes 101 to 111 are also tried at extreme pages to separate "all" from the reserved codes. Directed sequences then separate staging from committing, test stop with nothing pending, and test latch arming with the wrong order or a stray byte. They also check that the write-protect pin freezes only the lock field, and that a locked-page hit cancels a staged update.

// File: rtl/wpl_pkg.sv
package wpl_pkg;

  typedef struct packed {
    logic [1:0] wd;
    logic [2:0] lock;
    logic       rwel;
    logic       wel;
    logic       tadj;
  } ctl_reg_t;

  localparam logic [7:0] CMD_WEL_SET = 8'h02;
  localparam logic [7:0] CMD_RWEL_SET = 8'h06;
  localparam logic [7:0] CMD_WEL_CLR = 8'h00;

  // number of top pages covered by a lock code
  function automatic int unsigned lock_span(logic [2:0] code, int unsigned npages);
    case (code)
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 4;
      3'd4: return 8;
      3'd5: return npages;
      default: return 0;
    endcase
  endfunction

  // a page is locked when it lies in the top span of the array
  function automatic logic page_locked(int unsigned page, logic [2:0] code,
                                       int unsigned npages);
    return (page + lock_span(code, npages)) >= npages;
  endfunction

endpackage

// File: rtl/wpl_page_guard.sv
module wpl_page_guard
  import wpl_pkg::*;
#(
  parameter int PAGE_W = 6
) (
  input  logic [2:0]        lock_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              locked_o
);
  localparam int NPAGES = 1 << PAGE_W;

  logic [NPAGES-1:0] lock_map;

  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    assign lock_map[p] = page_locked(p, lock_i, NPAGES);
  end

  assign locked_o = lock_map[page_i];
endmodule

// File: rtl/wpl_latch_ctrl.sv
module wpl_latch_ctrl
  import wpl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_data_i,
  input  logic       stop_i,
  input  logic       prot_hit_i,
  output logic       wel_o,
  output logic       rwel_o,
  output logic       commit_evt_o,
  output logic [1:0] new_wd_o,
  output logic [2:0] new_lock_o,
  output logic       new_tadj_o
);
  logic     wel_q, rwel_q, pend_q;
  ctl_reg_t pend_q_data;
  ctl_reg_t din;
  logic     stage_evt;

  assign din          = ctl_reg_t'(reg_data_i);
  assign commit_evt_o = stop_i & pend_q & ~prot_hit_i;
  assign stage_evt    = reg_wr_i & rwel_q & wel_q & ~din.rwel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q       <= 1'b0;
      rwel_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_q_data <= '0;
    end else if (prot_hit_i) begin
      rwel_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (commit_evt_o) begin
      rwel_q <= 1'b0;
      wel_q  <= pend_q_data.wel;
      pend_q <= 1'b0;
    end else if (stage_evt) begin
      pend_q      <= 1'b1;
      pend_q_data <= din;
    end else if (reg_wr_i) begin
      if (reg_data_i == CMD_WEL_SET) begin
        wel_q <= 1'b1;
      end else if (reg_data_i == CMD_RWEL_SET && wel_q) begin
        rwel_q <= 1'b1;
      end else if (reg_data_i == CMD_WEL_CLR && !rwel_q) begin
        wel_q <= 1'b0;
      end
    end
  end

  assign wel_o      = wel_q;
  assign rwel_o     = rwel_q;
  assign new_wd_o   = pend_q_data.wd;
  assign new_lock_o = pend_q_data.lock;
  assign new_tadj_o = pend_q_data.tadj;
endmodule

// File: rtl/wpl_nv_store.sv
module wpl_nv_store (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit_evt_i,
  input  logic       wp_i,
  input  logic [1:0] new_wd_i,
  input  logic [2:0] new_lock_i,
  input  logic       new_tadj_i,
  output logic [1:0] wd_o,
  output logic [2:0] lock_o,
  output logic       tadj_o,
  output logic       commit_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_o     <= '0;
      lock_o   <= '0;
      tadj_o   <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= commit_evt_i;
      if (commit_evt_i) begin
        wd_o   <= new_wd_i;
        tadj_o <= new_tadj_i;
        if (!wp_i) lock_o <= new_lock_i;
      end
    end
  end
endmodule

// File: rtl/wpl_write_guard.sv
module wpl_write_guard
  import wpl_pkg::*;
#(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_data_i,
  input  logic              stop_i,
  input  logic              mem_req_i,
  input  logic [PAGE_W-1:0] mem_page_i,
  input  logic              wp_i,
  output logic              mem_grant_o,
  output logic              mem_deny_o,
  output logic [7:0]        reg_rdata_o,
  output logic              nv_commit_o
);
  logic       wel, rwel, commit_evt, page_lock, prot_hit, permit;
  logic [1:0] new_wd, wd;
  logic [2:0] new_lock, lock;
  logic       new_tadj, tadj;
  ctl_reg_t   rd;

  wpl_page_guard #(.PAGE_W(PAGE_W)) u_guard (
    .lock_i  (lock),
    .page_i  (mem_page_i),
    .locked_o(page_lock)
  );

  assign prot_hit = mem_req_i & wel & page_lock;
  assign permit   = wel & ~page_lock;

  wpl_latch_ctrl u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_data_i  (reg_data_i),
    .stop_i      (stop_i),
    .prot_hit_i  (prot_hit),
    .wel_o       (wel),
    .rwel_o      (rwel),
    .commit_evt_o(commit_evt),
    .new_wd_o    (new_wd),
    .new_lock_o  (new_lock),
    .new_tadj_o  (new_tadj)
  );

  wpl_nv_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_evt_i(commit_evt),
    .wp_i        (wp_i),
    .new_wd_i    (new_wd),
    .new_lock_i  (new_lock),
    .new_tadj_i  (new_tadj),
    .wd_o        (wd),
    .lock_o      (lock),
    .tadj_o      (tadj),
    .commit_o    (nv_commit_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_grant_o <= 1'b0;
      mem_deny_o  <= 1'b0;
    end else begin
      mem_grant_o <= mem_req_i & permit;
      mem_deny_o  <= mem_req_i & ~permit;
    end
  end

  always_comb begin
    rd.wd   = wd;
    rd.lock = lock;
    rd.rwel = rwel;
    rd.wel  = wel;
    rd.tadj = tadj;
  end
  assign reg_rdata_o = rd;
endmodule

// File: rtl/wpl_write_guard_chk.sv
module wpl_write_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_i,
  input logic       stop_i,
  input logic       mem_req_i,
  input logic       wp_i,
  input logic       mem_grant_o,
  input logic       mem_deny_o,
  input logic [7:0] reg_rdata_o,
  input logic       nv_commit_o,
  input logic       wel,
  input logic       rwel
);
  logic [5:0] nv_bits;
  assign nv_bits = {reg_rdata_o[7:3], reg_rdata_o[0]};

  assert_excl_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_grant_o, mem_deny_o}));

  assert_rwel_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel) |-> $past(wel));

  assert_nowel_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_i && !wel && !reg_wr_i && !stop_i) |=> (mem_deny_o && $stable(reg_rdata_o)));

  assert_nv_only_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_bits != $past(nv_bits)) |-> nv_commit_o);

  assert_commit_clears_rwel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nv_commit_o |-> !rwel);

  assert_hit_clears_rwel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_deny_o && $past(wel)) |-> !rwel);

  assert_wp_freezes_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_commit_o && $past(wp_i)) |-> (reg_rdata_o[5:3] == $past(reg_rdata_o[5:3])));
endmodule

bind wpl_write_guard wpl_write_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_i   (reg_wr_i),
  .stop_i     (stop_i),
  .mem_req_i  (mem_req_i),
  .wp_i       (wp_i),
  .mem_grant_o(mem_grant_o),
  .mem_deny_o (mem_deny_o),
  .reg_rdata_o(reg_rdata_o),
  .nv_commit_o(nv_commit_o),
  .wel        (wel),
  .rwel       (rwel)
);

// File: tb/tb_wpl_write_guard.sv
`timescale 1ns/1ps
module tb_wpl_write_guard;
  localparam int PAGE_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_i = 1'b0;
  logic [7:0]       reg_data_i = '0;
  logic             stop_i = 1'b0;
  logic             mem_req_i = 1'b0;
  logic [PAGE_W-1:0] mem_page_i = '0;
  logic             wp_i = 1'b0;
  logic             mem_grant_o, mem_deny_o, nv_commit_o;
  logic [7:0]       reg_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  logic g_s, d_s;

  always #10 clk = ~clk;

  wpl_write_guard #(.PAGE_W(PAGE_W)) dut (.*);

  // {lock code[2:0], page[5:0], expected grant}
  localparam logic [9:0] VEC [14] = '{
    {3'd0, 6'd63, 1'b1}, {3'd1, 6'd63, 1'b0}, {3'd1, 6'd62, 1'b1},
    {3'd2, 6'd62, 1'b0}, {3'd2, 6'd61, 1'b1}, {3'd3, 6'd60, 1'b0},
    {3'd3, 6'd59, 1'b1}, {3'd4, 6'd56, 1'b0}, {3'd4, 6'd55, 1'b1},
    {3'd5, 6'd0,  1'b0}, {3'd5, 6'd31, 1'b0}, {3'd6, 6'd63, 1'b1},
    {3'd7, 6'd63, 1'b1}, {3'd0, 6'd0,  1'b1}
  };

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); reg_wr_i = 1'b1; reg_data_i = b;
    @(negedge clk); reg_wr_i = 1'b0;
  endtask

  task automatic stp();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic mem(logic [PAGE_W-1:0] p);
    @(negedge clk); mem_req_i = 1'b1; mem_page_i = p;
    @(negedge clk); mem_req_i = 1'b0;
    g_s = mem_grant_o; d_s = mem_deny_o;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reg", reg_rdata_o, 8'h00);
    check("R1 outs", {5'b0, mem_grant_o, mem_deny_o, nv_commit_o}, 8'h00);

    // main table: lock decode
    wr(8'h02);
    for (int i = 0; i < 14; i++) begin
      wr(8'h02); wr(8'h06); wr({2'b00, VEC[i][9:7], 3'b010}); stp();
      mem(VEC[i][6:1]);
      check($sformatf("R5 vec%0d grant/deny", i), {6'b0, g_s, d_s},
            {6'b0, VEC[i][0], ~VEC[i][0]});
    end
    // return to reset-like state: clear fields and latch
    wr(8'h02); wr(8'h06); wr(8'h00); stp();
    check("R2 cleared", reg_rdata_o, 8'h00);

    mem(6'd5);
    check("R4 deny no wel", {6'b0, g_s, d_s}, 8'h01);
    check("R4 reg kept", reg_rdata_o, 8'h00);
    wr(8'h06);
    check("R3 rwel blocked", reg_rdata_o, 8'h00);
    wr(8'h04);
    check("R10 stray ignored", reg_rdata_o, 8'h00);
    wr(8'h02);
    check("R2 wel set", reg_rdata_o, 8'h02);
    wr(8'h06);
    check("R3 rwel set", reg_rdata_o, 8'h06);
    wr(8'hC9);
    check("R6 staged not visible", reg_rdata_o, 8'h06);
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    check("R6 commit strobe", {7'b0, nv_commit_o}, 8'h01);
    check("R6 committed", reg_rdata_o, 8'hC9);
    @(negedge clk);
    check("R6 strobe one cycle", {7'b0, nv_commit_o}, 8'h00);
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    check("R11 no strobe", {7'b0, nv_commit_o}, 8'h00);
    check("R11 reg kept", reg_rdata_o, 8'hC9);
    mem(6'd0);
    check("R4 deny locked state", {6'b0, g_s, d_s}, 8'h01);
    check("R4 reg kept 2", reg_rdata_o, 8'hC9);
    wr(8'h02);
    check("R2 set again", reg_rdata_o, 8'hCB);
    wr(8'h00);
    check("R2 clear", reg_rdata_o, 8'hC9);

    wr(8'h02); wr(8'h06); wr(8'h02); stp();
    check("R7 reset sequence", reg_rdata_o, 8'h02);

    wr(8'h06); wr(8'h22); stp();
    check("R8 lock 8 set", reg_rdata_o, 8'h22);
    wr(8'h06); wr(8'h03);
    mem(6'd60);
    check("R8 deny locked", {6'b0, g_s, d_s}, 8'h01);
    check("R8 rwel cleared", reg_rdata_o, 8'h22);
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    check("R8 no commit", {7'b0, nv_commit_o}, 8'h00);
    check("R8 staged dropped", reg_rdata_o, 8'h22);

    wp_i = 1'b1;
    wr(8'h06); wr(8'hCB); stp();
    check("R9 lock frozen", reg_rdata_o, 8'hE3);
    mem(6'd56);
    check("R9 still denied", {6'b0, g_s, d_s}, 8'h01);
    mem(6'd55);
    check("R9 free page", {6'b0, g_s, d_s}, 8'h02);
    wr(8'hFF);
    check("R10 FFh ignored", reg_rdata_o, 8'hE3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule